// File: doc/BRIEF.md
# Multiword DMA Strobe Sequencer for a Parallel Disk Bus

This block runs multiword DMA data transfers on a 16-bit parallel disk interface. It watches the device's DMA request line and brings that request into the system clock domain. When the block is enabled and the request is seen, it asserts the active-low DMA acknowledge. It then issues a train of active-low read or write strobes and keeps the acknowledge low across the whole train. Each word in the train is built from three counted phases. The lead-in runs from acknowledge to strobe. The strobe width comes next, then the recovery before the following strobe. The cycle counts for these phases come from one of two timing sets, one for each attached device.

On the host side, a single-word receive register holds each word read from the bus until a consumer pops it. Write words arrive through a valid/acknowledge handshake. The sequencer takes a write word only in the cycle its strobe begins. If no room is available (a full receive register, or no write word offered), the sequencer parks at the end of its current phase and asserts no strobe. When the device drops its request at the end of a recovery, the acknowledge is released and the burst ends.

Top module: `mdma_engine`

## Requirements
- R1: With `en` high, a rise of `dmarq` is seen through a two-stage synchronizer. `dmack_n` goes low and `tip` goes high on the third rising clock edge after `dmarq` is first sampled high.
- R2: The first strobe of a burst goes low Tm clock cycles after `dmack_n` goes low, given room for the word. A programmed value of 0 acts as 1.
- R3: A strobe stays low for Td cycles. Read bursts pulse only `dior_n`, write bursts pulse only `diow_n`, and the two are never low together or outside a low `dmack_n`.
- R4: After a strobe comes Teoc recovery cycles. If the synchronized request is still high, another strobe starts in the next cycle. Otherwise `dmack_n` and `tip` return high in the next cycle.
- R5: `dev_sel` is sampled when a burst starts: 0 picks the A timing set and 1 picks the B set. A change of `dev_sel` during a burst has no effect on that burst.
- R6: In a read burst, `dd_in` is captured into `rd_data` on the cycle the strobe rises, and `rd_valid` is set. `rd_valid` clears when `rd_ready` is high at a clock edge. No read strobe starts while `rd_valid` is high.
- R7: In a write burst, `wr_ack` is high in the cycle the strobe starts, and `wr_data` is then driven on `dd_out` throughout the strobe. `dd_oe` is high for the whole write burst. No write strobe starts without `wr_valid`.
- R8: A low `rst_n` forces `dmack_n`, `dior_n` and `diow_n` high and `tip`, `dd_oe` and `rd_valid` low at once. A low `en` at a clock edge forces the same bus and burst state (all but `rd_valid`) in the next cycle.
- R9: `dir_rd` is sampled at burst start (1 = read, 0 = write). A change of `dir_rd` during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | DMA enable |
| dir_rd | input | 1 | Direction, 1 read / 0 write, sampled at burst start |
| dev_sel | input | 1 | Timing set select, 0 = A, 1 = B |
| tm_a | input | TW | Set A lead-in cycles |
| td_a | input | TW | Set A strobe cycles |
| teoc_a | input | TW | Set A recovery cycles |
| tm_b | input | TW | Set B lead-in cycles |
| td_b | input | TW | Set B strobe cycles |
| teoc_b | input | TW | Set B recovery cycles |
| dmarq | input | 1 | Asynchronous device DMA request |
| wr_data | input | DW | Write word offered |
| wr_valid | input | 1 | Write word available |
| wr_ack | output | 1 | Write word taken this cycle |
| dd_in | input | DW | Data bus from device |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | Receive register holds a word |
| rd_ready | input | 1 | Consumer pops the receive register |
| dmack_n | output | 1 | Active-low DMA acknowledge |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| dd_out | output | DW | Data bus to device |
| dd_oe | output | 1 | Data bus output enable |
| tip | output | 1 | Transfer in progress |

## Verification
An off-by-one in a phase counter shows up at the bus pins on the first word of a burst, as a strobe that moves by one cycle. The cycle-by-cycle comparison catches it on the edge where it happens. A corrupted burst state, such as a lost direction or timing set, produces the wrong strobe pin or width within one word time. A receive-register fault appears as `rd_valid` or `rd_data` differing on the cycle after the strobe rises, or as a strobe issued while the register is full. A write-handshake fault appears as a mistimed `wr_ack` or a wrong `dd_out` in that same strobe.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_STROBE = 2'd2,
        ST_RECOV  = 2'd3
    } mdma_state_e;

endpackage

// File: rtl/mdma_sync.sv
module mdma_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/mdma_tsel.sv
module mdma_tsel #(
    parameter int TW = 8
) (
    input  logic          sel,
    input  logic [TW-1:0] tm_a,
    input  logic [TW-1:0] td_a,
    input  logic [TW-1:0] teoc_a,
    input  logic [TW-1:0] tm_b,
    input  logic [TW-1:0] td_b,
    input  logic [TW-1:0] teoc_b,
    output logic [TW-1:0] tm,
    output logic [TW-1:0] td,
    output logic [TW-1:0] teoc
);
    localparam int NSET = 2;

    logic [TW-1:0] tm_set [NSET];
    logic [TW-1:0] td_set [NSET];
    logic [TW-1:0] eoc_set[NSET];

    always_comb begin
        tm_set[0]  = tm_a;   tm_set[1]  = tm_b;
        td_set[0]  = td_a;   td_set[1]  = td_b;
        eoc_set[0] = teoc_a; eoc_set[1] = teoc_b;
        tm   = tm_set[sel];
        td   = td_set[sel];
        teoc = eoc_set[sel];
    end
endmodule

// File: rtl/mdma_rxreg.sv
module mdma_rxreg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          valid
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] word;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (rx_q.full && pop) rx_d.full = 1'b0;
        if (capture) begin
            rx_d.full = 1'b1;
            rx_d.word = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign dout  = rx_q.word;
    assign valid = rx_q.full;

    // R6: the sequencer never captures into an occupied register
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !rx_q.full);
endmodule

// File: rtl/mdma_engine.sv
module mdma_engine
    import mdma_pkg::*;
#(
    parameter int TW          = 8,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dir_rd,
    input  logic          dev_sel,
    input  logic [TW-1:0] tm_a,
    input  logic [TW-1:0] td_a,
    input  logic [TW-1:0] teoc_a,
    input  logic [TW-1:0] tm_b,
    input  logic [TW-1:0] td_b,
    input  logic [TW-1:0] teoc_b,
    input  logic          dmarq,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_valid,
    output logic          wr_ack,
    input  logic [DW-1:0] dd_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic          dmack_n,
    output logic          dior_n,
    output logic          diow_n,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic          tip
);
    localparam logic [TW-1:0] CNT_ZERO = '0;

    typedef struct packed {
        mdma_state_e   st;
        logic [TW-1:0] cnt;
        logic          set;
        logic          rd;
        logic [DW-1:0] dd;
        logic          ack_n;
        logic          rstb_n;
        logic          wstb_n;
        logic          oe;
        logic          busy;
    } ctl_t;

    ctl_t cq, cd;

    logic          req_s;
    logic          tsel;
    logic [TW-1:0] cur_tm, cur_td, cur_teoc;
    logic          capture;
    logic          wr_take;
    logic          go_strobe;
    logic          room;
    logic          cnt_done;

    function automatic logic [TW-1:0] phase_load(input logic [TW-1:0] t);
        return (t == CNT_ZERO) ? CNT_ZERO : t - 1'b1;
    endfunction

    mdma_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (dmarq),
        .q    (req_s)
    );

    assign tsel = (cq.st == ST_IDLE) ? dev_sel : cq.set;

    mdma_tsel #(.TW(TW)) u_tsel (
        .sel   (tsel),
        .tm_a  (tm_a),
        .td_a  (td_a),
        .teoc_a(teoc_a),
        .tm_b  (tm_b),
        .td_b  (td_b),
        .teoc_b(teoc_b),
        .tm    (cur_tm),
        .td    (cur_td),
        .teoc  (cur_teoc)
    );

    mdma_rxreg #(.DW(DW)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .din    (dd_in),
        .pop    (rd_ready),
        .dout   (rd_data),
        .valid  (rd_valid)
    );

    always_comb begin
        cd        = cq;
        capture   = 1'b0;
        wr_take   = 1'b0;
        go_strobe = 1'b0;
        cnt_done  = (cq.cnt == CNT_ZERO);
        room      = cq.rd ? !rd_valid : wr_valid;

        case (cq.st)
            ST_IDLE: begin
                if (req_s) begin
                    cd.st    = ST_LEAD;
                    cd.set   = dev_sel;
                    cd.rd    = dir_rd;
                    cd.ack_n = 1'b0;
                    cd.busy  = 1'b1;
                    cd.oe    = !dir_rd;
                    cd.cnt   = phase_load(cur_tm);
                end
            end
            ST_LEAD: begin
                if (!cnt_done)  cd.cnt = cq.cnt - 1'b1;
                else if (room)  go_strobe = 1'b1;
            end
            ST_STROBE: begin
                if (!cnt_done) begin
                    cd.cnt = cq.cnt - 1'b1;
                end else begin
                    cd.st     = ST_RECOV;
                    cd.cnt    = phase_load(cur_teoc);
                    cd.rstb_n = 1'b1;
                    cd.wstb_n = 1'b1;
                    capture   = cq.rd;
                end
            end
            ST_RECOV: begin
                if (!cnt_done) begin
                    cd.cnt = cq.cnt - 1'b1;
                end else if (!req_s) begin
                    cd.st    = ST_IDLE;
                    cd.ack_n = 1'b1;
                    cd.busy  = 1'b0;
                    cd.oe    = 1'b0;
                end else if (room) begin
                    go_strobe = 1'b1;
                end
            end
            default: cd.st = ST_IDLE;
        endcase

        if (go_strobe) begin
            cd.st     = ST_STROBE;
            cd.cnt    = phase_load(cur_td);
            cd.rstb_n = !cq.rd;
            cd.wstb_n = cq.rd;
            if (!cq.rd) begin
                cd.dd   = wr_data;
                wr_take = 1'b1;
            end
        end

        if (!en) begin
            cd.st     = ST_IDLE;
            cd.cnt    = CNT_ZERO;
            cd.ack_n  = 1'b1;
            cd.rstb_n = 1'b1;
            cd.wstb_n = 1'b1;
            cd.oe     = 1'b0;
            cd.busy   = 1'b0;
            capture   = 1'b0;
            wr_take   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq        <= '0;
            cq.st     <= ST_IDLE;
            cq.ack_n  <= 1'b1;
            cq.rstb_n <= 1'b1;
            cq.wstb_n <= 1'b1;
        end else begin
            cq <= cd;
        end
    end

    assign wr_ack  = wr_take;
    assign dmack_n = cq.ack_n;
    assign dior_n  = cq.rstb_n;
    assign diow_n  = cq.wstb_n;
    assign dd_out  = cq.dd;
    assign dd_oe   = cq.oe;
    assign tip     = cq.busy;

    // R3: strobes are exclusive
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));
    // R3: a strobe only inside an acknowledged burst
    a_r3_strobe_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> !dmack_n);
    // R8: disable empties the bus next cycle
    a_r8_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dmack_n && dior_n && diow_n && !tip && !dd_oe));
    // R7: a taken word starts a write strobe
    a_r7_ack_starts_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !diow_n);
    // R7: bus drive never overlaps a read strobe
    a_r7_oe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe |-> dior_n);
    // R4: acknowledge released only for a dropped request or disable
    a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n) |-> ($past(!req_s) || $past(!en)));
    // R6: a read strobe never starts into a full receive register
    a_r6_read_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dior_n) |-> $past(!rd_valid));
endmodule

// File: tb/mdma_engine_bench.sv
module mdma_engine_bench;
    localparam int TW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, dir_rd = 1'b1, dev_sel = 1'b0, dmarq = 1'b0;
    logic [TW-1:0] tm_a = 8'd3, td_a = 8'd4, teoc_a = 8'd2;
    logic [TW-1:0] tm_b = 8'd0, td_b = 8'd2, teoc_b = 8'd3;
    logic [DW-1:0] wr_data = 16'h1000, dd_in = 16'h0;
    logic          wr_valid = 1'b0, rd_ready = 1'b1;
    logic          wr_ack, rd_valid, dmack_n, dior_n, diow_n, dd_oe, tip;
    logic [DW-1:0] rd_data, dd_out;

    int checks = 0, fails = 0, cyc = 0;
    int rd_mode = 0, wr_mode = 0;
    logic started = 1'b0, ack_seen = 1'b0;

    always #2 clk = ~clk;

    mdma_engine u_mdma_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_rd(dir_rd), .dev_sel(dev_sel),
        .tm_a(tm_a), .td_a(td_a), .teoc_a(teoc_a),
        .tm_b(tm_b), .td_b(td_b), .teoc_b(teoc_b),
        .dmarq(dmarq), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ack(wr_ack),
        .dd_in(dd_in), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .tip(tip)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    // behavioural reference model
    int   m_ph = 0, m_left = 0;
    logic m_rd = 1'b1, m_set = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0, m_rdv = 1'b0;
    logic [DW-1:0] m_rdd = '0, m_dd = '0;

    function automatic int span(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int pick(input logic s, input int which);
        if (which == 0) return span(s ? int'(tm_b) : int'(tm_a));
        if (which == 1) return span(s ? int'(td_b) : int'(td_a));
        return span(s ? int'(teoc_b) : int'(teoc_a));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_s1 = 0; m_s2 = 0; m_rdv = 0;
            m_rdd = '0; m_dd = '0; m_rd = 1'b0; m_set = 1'b0;
        end else begin
            automatic logic req = m_s2;
            automatic logic has_room = m_rd ? !m_rdv : wr_valid;
            automatic logic strobe_now = 1'b0;
            automatic logic rdv_pop = m_rdv && rd_ready;
            m_s2 = m_s1;
            m_s1 = dmarq;
            if (rdv_pop) m_rdv = 1'b0;
            if (!en) begin
                m_ph = 0;
            end else begin
                case (m_ph)
                    0: if (req) begin
                        m_ph = 1; m_set = dev_sel; m_rd = dir_rd;
                        m_left = pick(dev_sel, 0) - 1;
                    end
                    1: if (m_left > 0) m_left--; else if (has_room) strobe_now = 1;
                    2: if (m_left > 0) m_left--;
                       else begin
                           m_ph = 3; m_left = pick(m_set, 2) - 1;
                           if (m_rd) begin m_rdv = 1'b1; m_rdd = dd_in; end
                       end
                    default: if (m_left > 0) m_left--;
                             else if (!req) m_ph = 0;
                             else if (has_room) strobe_now = 1;
                endcase
                if (strobe_now) begin
                    m_ph = 2; m_left = pick(m_set, 1) - 1;
                    if (!m_rd) m_dd = wr_data;
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (started && rst_n) begin
            automatic logic e_ack = en && !m_rd && wr_valid && m_left == 0 &&
                                    (m_ph == 1 || (m_ph == 3 && m_s2));
            chk(dmack_n == (m_ph == 0), "R4 dmack_n", 32'(dmack_n), 32'(m_ph == 0));
            chk(tip == (m_ph != 0), "R1 tip", 32'(tip), 32'(m_ph != 0));
            chk(dior_n == !(m_ph == 2 && m_rd), "R3 dior_n", 32'(dior_n), 32'(!(m_ph == 2 && m_rd)));
            chk(diow_n == !(m_ph == 2 && !m_rd), "R3 diow_n", 32'(diow_n), 32'(!(m_ph == 2 && !m_rd)));
            chk(dd_oe == (m_ph != 0 && !m_rd), "R7 dd_oe", 32'(dd_oe), 32'(m_ph != 0 && !m_rd));
            chk(wr_ack == e_ack, "R7 wr_ack", 32'(wr_ack), 32'(e_ack));
            chk(rd_valid == m_rdv, "R6 rd_valid", 32'(rd_valid), 32'(m_rdv));
            if (m_rdv) chk(rd_data == m_rdd, "R6 rd_data", 32'(rd_data), 32'(m_rdd));
            if (m_ph == 2 && !m_rd) chk(dd_out == m_dd, "R7 dd_out", 32'(dd_out), 32'(m_dd));
        end
    end

    // data sources
    always @(posedge clk) ack_seen <= wr_ack;
    always @(negedge clk) begin
        #1;
        cyc++;
        dd_in = 16'(cyc * 16'h1357 + 16'h00a5);
        rd_ready = (rd_mode == 0) ? 1'b1 : (rd_mode == 1) ? (cyc % 7 < 2) : 1'b0;
        if (ack_seen) wr_data = wr_data + 16'h0011;
        wr_valid = (wr_mode == 0) ? 1'b0 : (cyc % 5 != 0);
    end

    // watchdog
    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic wait_low(input int which, input string tag);
        int n = 0;
        while ((which == 0 ? dior_n : diow_n) && n < 200) begin tick(1); n++; end
        chk(n < 200, tag, 32'(n), 32'd200);
    endtask

    initial begin
        int lows;
        tick(2);
        started = 1'b1;
        // R8: reset state
        chk(dmack_n && dior_n && diow_n && !tip && !dd_oe && !rd_valid, "R8 reset",
            {dmack_n, dior_n, diow_n, tip, dd_oe, rd_valid}, 32'h38);
        rst_n = 1'b1;
        tick(2);

        // read burst, set A
        en = 1; dir_rd = 1; dev_sel = 0; rd_mode = 2;
        dmarq = 1;
        tick(2);
        chk(dmack_n == 1'b1, "R1 not before third edge", 32'(dmack_n), 32'd1);
        tick(1);
        chk(dmack_n == 1'b0 && tip, "R1 acknowledge on third edge", 32'(dmack_n), 32'd0);
        tick(2);
        chk(dior_n == 1'b1, "R2 lead-in still running", 32'(dior_n), 32'd1);
        tick(1);
        chk(dior_n == 1'b0, "R2 strobe after Tm", 32'(dior_n), 32'd0);
        tick(3);
        chk(dior_n == 1'b0, "R3 strobe held for Td", 32'(dior_n), 32'd0);
        tick(1);
        chk(dior_n == 1'b1 && rd_valid, "R6 capture at strobe end", 32'(rd_valid), 32'd1);
        lows = 0;
        for (int i = 0; i < 20; i++) begin tick(1); if (!dior_n) lows++; end
        chk(lows == 0, "R6 no strobe while receive full", 32'(lows), 32'd0);
        rd_mode = 1;
        tick(40);
        dir_rd = 0; dev_sel = 1;  // R9 and R5: ignored mid-burst
        lows = 0;
        for (int i = 0; i < 40; i++) begin tick(1); if (!diow_n) lows++; end
        chk(lows == 0, "R9 direction change ignored", 32'(lows), 32'd0);
        dmarq = 0;
        tick(30);
        chk(dmack_n && !tip, "R4 release after request drop", 32'(dmack_n), 32'd1);

        // write burst, set B (Tm of 0 acts as 1)
        rd_mode = 0; wr_mode = 1; dir_rd = 0; dev_sel = 1;
        dmarq = 1;
        tick(3);
        chk(!dmack_n && dd_oe, "R7 output enable in write burst", 32'(dd_oe), 32'd1);
        wait_low(1, "R7 write strobe seen");
        tick(1);
        chk(diow_n == 1'b0, "R5 set B width first cycle", 32'(diow_n), 32'd0);
        tick(1);
        chk(diow_n == 1'b1, "R5 set B width ends", 32'(diow_n), 32'd1);
        dev_sel = 0;
        tick(60);
        wr_mode = 0;
        tick(30);
        lows = 0;
        for (int i = 0; i < 20; i++) begin tick(1); if (!diow_n) lows++; end
        chk(lows == 0, "R7 no write strobe without a word", 32'(lows), 32'd0);
        wr_mode = 1;
        dmarq = 0;
        tick(30);

        // disable mid-strobe
        dir_rd = 1; dev_sel = 0; dmarq = 1;
        wait_low(0, "R8 read strobe seen");
        en = 0;
        tick(1);
        chk(dmack_n && dior_n && diow_n && !tip, "R8 disable idles bus",
            {dmack_n, dior_n, diow_n, tip}, 32'he);
        tick(5);
        en = 1;
        wait_low(0, "R8 burst resumes");
        rst_n = 0;
        #0.5;
        chk(dmack_n && dior_n && !tip && !rd_valid, "R8 asynchronous reset",
            {dmack_n, dior_n, tip, rd_valid}, 32'hc);
        tick(2);
        rst_n = 1; dmarq = 0;
        tick(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule